// File: doc/BRIEF.md
# Halt-Mode Wake-Up Sequencer

This block is the power-state controller that sits beside a small microcontroller core. When the core decodes the halt opcode, the controller stops the main oscillator and holds the CPU and its peripherals stopped. It can also drop the internal regulator into powerdown and switch off the I/O slew-rate compensation, each according to a setting captured when the halt is accepted. At the same moment it sends a one-cycle request to clear the interrupt mask bits, so that interrupts are enabled while the device sleeps.

Only a reset or an interrupt line that is both pending and marked wake-capable ends the halt. Every wake turns the oscillator back on straight away. The CPU then stays stopped for a fixed stabilization count. After that count, a reset wake resumes in low-power mode and asks the core to fetch the reset vector. An interrupt wake resumes in the power mode the core was in before the halt. A full-power resume also waits until the external PLL reports lock. The oscillator, the PLL and the interrupt controller sit outside the block and connect only through plain signals.

Top module: `halt_wake_seq`

## Requirements
- R1: A halt is accepted only in the running state, on a cycle where instr_valid is 1 and instr_opcode equals 0x8E. Any other opcode, or the halt opcode with instr_valid at 0, leaves cpu_run and osc_enable at 1.
- R2: While halted, osc_enable is 0 and cpu_run is 0. osc_enable is 1 in every other state.
- R3: clear_int_mask is high for exactly one cycle, the cycle that follows the accepting clock edge.
- R4: Only a line whose irq_pending bit and irq_wake_en bit are both 1 ends a halt. A pending line with its enable at 0 leaves osc_enable at 0.
- R5: If an enabled wake line is already pending when the halt is accepted, the block goes straight to the stabilization count. osc_enable never drops.
- R6: Between a wake and the resume, osc_enable is 1 and cpu_run is 0 for exactly 512 cycles of stabilization. A full-power resume adds the PLL wait to this.
- R7: rst, in any state, restarts the 512-cycle count. The resume that follows is in low-power mode (run_full_power 0), and fetch_reset_vec is 1 during the first cycle in which cpu_run is 1, and in no other cycle.
- R8: After an interrupt wake from a low-power halt, cpu_run rises in the cycle right after the count ends, with run_full_power 0 and fetch_reset_vec 0.
- R9: After an interrupt wake from a full-power halt, cpu_run stays 0 until pll_locked has been sampled 1 in the waiting state. If pll_locked is already 1, the wait takes one cycle. The resume has run_full_power 1.
- R10: regulator_pd and slew_comp_off follow reg_off_cfg and slew_off_cfg as captured at the accepting edge. They are 1 only while halted, and later changes to the settings have no effect.
- R11: The pre-halt mode is taken from full_power_mode at the accepting edge. Changes to full_power_mode during the halt do not alter the resume mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; also acts as a reset wake |
| instr_valid | input | 1 | Decoded instruction valid |
| instr_opcode | input | 8 | Decoded opcode |
| full_power_mode | input | 1 | Current core power mode, 1 = full power |
| reg_off_cfg | input | 1 | Request regulator powerdown during halt |
| slew_off_cfg | input | 1 | Request slew compensation stop during halt |
| irq_pending | input | 4 | Pending interrupt lines |
| irq_wake_en | input | 4 | Wake-capable mask per line |
| pll_locked | input | 1 | PLL lock indication |
| osc_enable | output | 1 | Main oscillator enable |
| regulator_pd | output | 1 | Regulator powerdown |
| slew_comp_off | output | 1 | Slew-rate compensation stop |
| cpu_run | output | 1 | CPU and peripherals clocked |
| fetch_reset_vec | output | 1 | Fetch the reset vector on this resume |
| clear_int_mask | output | 1 | One-cycle request to clear interrupt mask bits |
| run_full_power | output | 1 | Mode used after the latest resume, 1 = full |

## Verification
The hardest state to reach is a reset that lands while the block is waiting for PLL lock. The bench gets there with an interrupt wake from a full-power halt, with pll_locked held low. It counts negative edges from the oscillator turning on until it is a few cycles past the 512-cycle count, then pulses rst. The scoreboard then expects a single resume, with the reset-vector fetch in low-power mode, after a total stall of 1029 cycles. The bench also reaches the pending-at-entry wake by raising an enabled line before issuing the halt opcode.

// File: rtl/hws_pkg.sv
package hws_pkg;
  typedef enum logic [2:0] {
    ST_RUN    = 3'd0,
    ST_HALTED = 3'd1,
    ST_SETTLE = 3'd2,
    ST_WAIT_PLL = 3'd3,
    ST_RESUME = 3'd4
  } hws_state_t;

  typedef enum logic {
    CAUSE_RST = 1'b0,
    CAUSE_IRQ = 1'b1
  } hws_cause_t;
endpackage

// File: rtl/hws_halt_detect.sv
module hws_halt_detect #(
  parameter int OPC_W = 8,
  parameter logic [OPC_W-1:0] HALT_OP = 8'h8E
) (
  input  logic             valid,
  input  logic [OPC_W-1:0] opcode,
  output logic             hit
);
  always_comb hit = valid && (opcode == HALT_OP);
endmodule

// File: rtl/hws_wake_detect.sv
module hws_wake_detect #(
  parameter int NUM_IRQ = 4
) (
  input  logic [NUM_IRQ-1:0] pending,
  input  logic [NUM_IRQ-1:0] wake_en,
  output logic               wake_any
);
  logic [NUM_IRQ-1:0] armed;
  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_line
    assign armed[i] = pending[i] & wake_en[i];
  end
  assign wake_any = |armed;
endmodule

// File: rtl/hws_settle_timer.sv
module hws_settle_timer #(
  parameter int CYCLES = 512
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  output logic done
);
  localparam int CNT_W = (CYCLES > 1) ? $clog2(CYCLES) : 1;
  localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(CYCLES - 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || load)   cnt <= LOAD_VAL;
    else if (cnt != '0) cnt <= cnt - 1'b1;
  end

  assign done = (cnt == '0);

  // R6
  tmr_load_chk: assert property (@(posedge clk) disable iff (rst)
    load |=> (cnt == LOAD_VAL));
  // R6
  tmr_step_chk: assert property (@(posedge clk) disable iff (rst)
    (!load && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));
endmodule

// File: rtl/halt_wake_seq.sv
module halt_wake_seq
  import hws_pkg::*;
#(
  parameter int OPC_W = 8,
  parameter logic [OPC_W-1:0] HALT_OP = 8'h8E,
  parameter int NUM_IRQ = 4,
  parameter int SETTLE_CYCLES = 512
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               instr_valid,
  input  logic [OPC_W-1:0]   instr_opcode,
  input  logic               full_power_mode,
  input  logic               reg_off_cfg,
  input  logic               slew_off_cfg,
  input  logic [NUM_IRQ-1:0] irq_pending,
  input  logic [NUM_IRQ-1:0] irq_wake_en,
  input  logic               pll_locked,
  output logic               osc_enable,
  output logic               regulator_pd,
  output logic               slew_comp_off,
  output logic               cpu_run,
  output logic               fetch_reset_vec,
  output logic               clear_int_mask,
  output logic               run_full_power
);
  hws_state_t state, state_n;
  hws_cause_t cause, cause_n;
  logic halt_hit, wake_any, tmr_done, tmr_load;
  logic was_full, reg_sel, slew_sel;
  logic accept, reg_pick, slew_pick;

  hws_halt_detect #(.OPC_W(OPC_W), .HALT_OP(HALT_OP)) u_dec (
    .valid(instr_valid), .opcode(instr_opcode), .hit(halt_hit));

  hws_wake_detect #(.NUM_IRQ(NUM_IRQ)) u_wake (
    .pending(irq_pending), .wake_en(irq_wake_en), .wake_any(wake_any));

  hws_settle_timer #(.CYCLES(SETTLE_CYCLES)) u_tmr (
    .clk(clk), .rst(rst), .load(tmr_load), .done(tmr_done));

  assign accept    = (state == ST_RUN) && halt_hit;
  assign reg_pick  = accept ? reg_off_cfg  : reg_sel;
  assign slew_pick = accept ? slew_off_cfg : slew_sel;

  always_comb begin
    state_n  = state;
    cause_n  = cause;
    tmr_load = 1'b0;
    unique case (state)
      ST_RUN: if (halt_hit) begin
        if (wake_any) begin
          state_n = ST_SETTLE; cause_n = CAUSE_IRQ; tmr_load = 1'b1;
        end else begin
          state_n = ST_HALTED;
        end
      end
      ST_HALTED: if (wake_any) begin
        state_n = ST_SETTLE; cause_n = CAUSE_IRQ; tmr_load = 1'b1;
      end
      ST_SETTLE: if (tmr_done) begin
        if (cause == CAUSE_RST || !was_full) state_n = ST_RESUME;
        else                                 state_n = ST_WAIT_PLL;
      end
      ST_WAIT_PLL: if (pll_locked) state_n = ST_RESUME;
      ST_RESUME: state_n = ST_RUN;
      default: state_n = ST_SETTLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state           <= ST_SETTLE;
      cause           <= CAUSE_RST;
      was_full        <= 1'b0;
      reg_sel         <= 1'b0;
      slew_sel        <= 1'b0;
      osc_enable      <= 1'b1;
      regulator_pd    <= 1'b0;
      slew_comp_off   <= 1'b0;
      cpu_run         <= 1'b0;
      fetch_reset_vec <= 1'b0;
      clear_int_mask  <= 1'b0;
      run_full_power  <= 1'b0;
    end else begin
      state <= state_n;
      cause <= cause_n;
      if (accept) begin
        was_full <= full_power_mode;
        reg_sel  <= reg_off_cfg;
        slew_sel <= slew_off_cfg;
      end
      osc_enable      <= (state_n != ST_HALTED);
      regulator_pd    <= (state_n == ST_HALTED) && reg_pick;
      slew_comp_off   <= (state_n == ST_HALTED) && slew_pick;
      cpu_run         <= (state_n == ST_RUN) || (state_n == ST_RESUME);
      fetch_reset_vec <= (state_n == ST_RESUME) && (cause == CAUSE_RST);
      clear_int_mask  <= accept;
      if (state_n == ST_RESUME)
        run_full_power <= (cause == CAUSE_IRQ) && was_full;
    end
  end

  // R2
  osc_halt_chk: assert property (@(posedge clk) disable iff (rst)
    !osc_enable |-> !cpu_run);
  // R7
  fetch_lowpwr_chk: assert property (@(posedge clk) disable iff (rst)
    fetch_reset_vec |-> (cpu_run && !run_full_power));
  // R9
  pll_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_WAIT_PLL && !pll_locked) |=> !cpu_run);
  // R10
  pd_only_halt_chk: assert property (@(posedge clk) disable iff (rst)
    (regulator_pd || slew_comp_off) |-> !osc_enable);
  // R3
  clr_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    clear_int_mask |=> !clear_int_mask);
  // R4
  no_wake_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_HALTED && !wake_any) |=> !osc_enable);
endmodule

// File: tb/halt_wake_seq_test.sv
module halt_wake_seq_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic instr_valid = 1'b0;
  logic [7:0] instr_opcode = 8'h00;
  logic full_power_mode = 1'b0;
  logic reg_off_cfg = 1'b0;
  logic slew_off_cfg = 1'b0;
  logic [3:0] irq_pending = 4'h0;
  logic [3:0] irq_wake_en = 4'h0;
  logic pll_locked = 1'b0;
  logic osc_enable, regulator_pd, slew_comp_off, cpu_run;
  logic fetch_reset_vec, clear_int_mask, run_full_power;

  halt_wake_seq uut (
    .clk(clk), .rst(rst), .instr_valid(instr_valid), .instr_opcode(instr_opcode),
    .full_power_mode(full_power_mode), .reg_off_cfg(reg_off_cfg),
    .slew_off_cfg(slew_off_cfg), .irq_pending(irq_pending),
    .irq_wake_en(irq_wake_en), .pll_locked(pll_locked),
    .osc_enable(osc_enable), .regulator_pd(regulator_pd),
    .slew_comp_off(slew_comp_off), .cpu_run(cpu_run),
    .fetch_reset_vec(fetch_reset_vec), .clear_int_mask(clear_int_mask),
    .run_full_power(run_full_power));

  always #2.5 clk = ~clk;

  typedef struct {
    bit fetch;
    bit full;
    int stall;
    bit halted;
  } exp_t;

  exp_t exp_q[$];
  int checks = 0;
  int errors = 0;
  int stall_cnt = 0;
  bit halted_seen = 1'b0;
  bit prev_run = 1'b0;
  int cyc = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Scoreboard monitor: one expected item per rising cpu_run
  always @(negedge clk) begin
    if (cpu_run === 1'b1 && !prev_run) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "unexpected resume", 1, 0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        chk(fetch_reset_vec == e.fetch, "R7/R8 fetch_reset_vec", fetch_reset_vec, e.fetch);
        chk(run_full_power == e.full, "R9/R11 run_full_power", run_full_power, e.full);
        chk(stall_cnt == e.stall, "R6 stall cycles", stall_cnt, e.stall);
        chk(halted_seen == e.halted, "R5 halted seen", halted_seen, e.halted);
      end
    end
    if (cpu_run === 1'b1) begin
      stall_cnt = 0;
      halted_seen = 1'b0;
    end else if (cpu_run === 1'b0) begin
      if (osc_enable) stall_cnt++;
      else halted_seen = 1'b1;
    end
    prev_run = (cpu_run === 1'b1);
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic push(input bit f, input bit fu, input int st, input bit h);
    exp_t e;
    e.fetch = f; e.full = fu; e.stall = st; e.halted = h;
    exp_q.push_back(e);
  endtask

  task automatic do_halt(input logic [7:0] op, input logic v);
    instr_valid = v;
    instr_opcode = op;
    @(negedge clk);
    instr_valid = 1'b0;
    instr_opcode = 8'h00;
  endtask

  task automatic wait_resume();
    while (exp_q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic wait_osc_on();
    while (osc_enable !== 1'b1) @(negedge clk);
  endtask

  initial begin
    // R7: reset held 3 edges, then settle and reset-vector resume
    push(1'b1, 1'b0, 514, 1'b0);
    @(negedge clk);
    chk(osc_enable == 1'b1 && cpu_run == 1'b0, "R7 reset state osc/run", {osc_enable, cpu_run}, 2);
    chk(regulator_pd == 1'b0 && clear_int_mask == 1'b0, "R7 reset state pd/clr", {regulator_pd, clear_int_mask}, 0);
    repeat (2) @(negedge clk);
    rst = 1'b0;
    wait_resume();
    chk(cpu_run == 1'b1 && fetch_reset_vec == 1'b0, "R7 fetch one cycle", {cpu_run, fetch_reset_vec}, 2);

    // R1: wrong opcode and invalid halt opcode ignored
    do_halt(8'h8F, 1'b1);
    chk(cpu_run == 1'b1 && osc_enable == 1'b1, "R1 wrong opcode", {cpu_run, osc_enable}, 3);
    do_halt(8'h8E, 1'b0);
    chk(cpu_run == 1'b1 && osc_enable == 1'b1, "R1 invalid halt", {cpu_run, osc_enable}, 3);

    // R2/R3/R10/R11/R4/R8: low-power halt, settings captured at accept
    reg_off_cfg = 1'b1; slew_off_cfg = 1'b0; full_power_mode = 1'b0;
    do_halt(8'h8E, 1'b1);
    chk(osc_enable == 1'b0 && cpu_run == 1'b0, "R2 halted outputs", {osc_enable, cpu_run}, 0);
    chk(clear_int_mask == 1'b1, "R3 clear pulse high", clear_int_mask, 1);
    chk(regulator_pd == 1'b1 && slew_comp_off == 1'b0, "R10 pd/slew", {regulator_pd, slew_comp_off}, 2);
    reg_off_cfg = 1'b0; slew_off_cfg = 1'b1; full_power_mode = 1'b1;
    @(negedge clk);
    chk(clear_int_mask == 1'b0, "R3 clear pulse low", clear_int_mask, 0);
    irq_pending = 4'b0010; irq_wake_en = 4'b0000;
    repeat (5) @(negedge clk);
    chk(osc_enable == 1'b0, "R4 masked irq ignored", osc_enable, 0);
    chk(regulator_pd == 1'b1 && slew_comp_off == 1'b0, "R10 late cfg ignored", {regulator_pd, slew_comp_off}, 2);
    push(1'b0, 1'b0, 512, 1'b1);  // R8, R11: low-power resume despite mode change
    irq_wake_en = 4'b0010;
    wait_resume();
    irq_pending = 4'h0;
    chk(regulator_pd == 1'b0 && slew_comp_off == 1'b0, "R10 cleared on run", {regulator_pd, slew_comp_off}, 0);

    // R9: full-power halt, lock arrives 20 cycles after the count
    full_power_mode = 1'b1; pll_locked = 1'b0; irq_wake_en = 4'b0001;
    do_halt(8'h8E, 1'b1);
    repeat (3) @(negedge clk);
    push(1'b0, 1'b1, 532, 1'b1);
    irq_pending = 4'b0001;
    wait_osc_on();
    repeat (521) @(negedge clk);
    chk(cpu_run == 1'b0, "R9 waiting for lock", cpu_run, 0);
    repeat (10) @(negedge clk);
    pll_locked = 1'b1;
    wait_resume();
    irq_pending = 4'h0;

    // R9: lock already present, one wait cycle
    do_halt(8'h8E, 1'b1);
    repeat (3) @(negedge clk);
    push(1'b0, 1'b1, 513, 1'b1);
    irq_pending = 4'b0001;
    wait_resume();
    irq_pending = 4'h0;

    // R5: enabled wake pending at entry
    full_power_mode = 1'b0; irq_wake_en = 4'b0100; irq_pending = 4'b0100;
    push(1'b0, 1'b0, 512, 1'b0);
    do_halt(8'h8E, 1'b1);
    chk(osc_enable == 1'b1 && cpu_run == 1'b0, "R5 osc kept on", {osc_enable, cpu_run}, 2);
    chk(clear_int_mask == 1'b1, "R3 clear on immediate wake", clear_int_mask, 1);
    wait_resume();
    irq_pending = 4'h0;

    // R7: reset while halted
    do_halt(8'h8E, 1'b1);
    repeat (4) @(negedge clk);
    push(1'b1, 1'b0, 512, 1'b1);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    wait_resume();

    // R7: reset while waiting for PLL after a full-power halt
    full_power_mode = 1'b1; pll_locked = 1'b0; irq_wake_en = 4'b1000;
    do_halt(8'h8E, 1'b1);
    repeat (2) @(negedge clk);
    push(1'b1, 1'b0, 1029, 1'b1);
    irq_pending = 4'b1000;
    wait_osc_on();
    repeat (516) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    irq_pending = 4'h0;
    wait_resume();
    chk(run_full_power == 1'b0, "R7 low power after reset", run_full_power, 0);

    chk(exp_q.size() == 0, "scoreboard drained", exp_q.size(), 0);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule